// File: doc/BRIEF.md
# Hash Job Sequencer

This block steps one hash or HMAC job through a block-based digest core. Software programs a mode word, an optional starting byte count and a byte length over a small register-write port. The write of the length launches the job. From then on the sequencer decides block by block what the external compression core must do next: run the HMAC key block, hash a 64-byte slice of message data, hash a short final slice with padding, hash a padding-only block, or run the HMAC outer hash. It keeps the remaining byte count and the processed byte count, and it clears each one-shot mode bit when the step that uses it completes.

Each block goes to the core as a request on a valid/ready channel. The request carries the step kind, the number of message bytes, a padding flag, a seed-from-constants flag and the algorithm code. The sequencer raises valid with stable fields and holds it until ready is high at a clock edge. It does not raise a new request until the core returns a one-cycle done pulse for the accepted block, so the core may stall either on accept or on completion. A context-switch request stops the job cleanly at the next block boundary while message bytes remain. The block then leaves the mode, the count and the remaining length readable so that the job can be resumed by writing the length again.

Top module: `hash_job_seq`

## Requirements
- R1: Mode bits are: [2:1] algorithm (0 = 128-bit MD5-style, 1 = SHA-1, 2 = SHA-224, 3 = SHA-256), bit 3 seed from algorithm constants, bit 4 close with padding, bit 5 HMAC key step, bit 7 HMAC outer step. Bits 0 and 6 read as 0. The algorithm code appears on `blk_algo`.
- R2: Writing the length (`cfg_sel` = 2) while idle or suspended starts a job. `busy` is high from the next cycle until the last step ends, at which point `job_done` pulses for one cycle and `busy` falls in the same cycle.
- R3: Writes of the mode (`cfg_sel` = 0), the count (`cfg_sel` = 1) or the length made while `busy` is high have no effect.
- R4: A count write stores the value with its lower 6 bits forced to 0.
- R5: With the seed bit set at start, the count becomes 0. The first data block is requested with `blk_seed_const` high, and the seed bit clears when that block is done.
- R6: With the key bit set at start, the count becomes 64. The first request has kind 1 (key), the key bit clears when it is done, and data hashing follows.
- R7: Data requests have kind 0 and carry min(remaining, 64) bytes. On each done, the remaining length drops by that amount and the count rises by it.
- R8: With close set, a final slice shorter than 64 bytes is requested with `blk_pad` high. If the length runs out on a 64-byte boundary, a padding-only request (0 bytes, pad high) follows. Close clears when the padded block is done.
- R9: With the outer bit set, one request of kind 2 follows the inner hash and the outer bit clears when it is done. A zero length with only the outer bit set runs the outer step alone.
- R10: A raised request keeps valid and its fields stable until accepted. Exactly one request is in flight, and none is raised between acceptance and the done pulse.
- R11: A context-switch pulse during a job suspends it after the block in flight, if message bytes remain. `suspended` goes high, `busy` goes low, and the mode, count and remaining length hold. Writing the length resumes the job. If no message bytes remain, the job completes normally instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 count, 2 length |
| cfg_wdata | input | 32 | Write data |
| ctx_sw_req | input | 1 | Context-switch request pulse |
| blk_valid | output | 1 | Block request valid |
| blk_ready | input | 1 | Core accepts the request |
| blk_kind | output | 2 | 0 data, 1 HMAC key, 2 HMAC outer |
| blk_bytes | output | 7 | Message bytes in this block (0..64) |
| blk_pad | output | 1 | Apply final padding in this block |
| blk_seed_const | output | 1 | Seed the digest from algorithm constants |
| blk_algo | output | 2 | Algorithm code |
| blk_done | input | 1 | Core finished the accepted block |
| busy | output | 1 | Job in progress |
| job_done | output | 1 | One-cycle pulse at job end |
| suspended | output | 1 | Job parked by a context switch |
| mode_q | output | 8 | Current mode word |
| count_q | output | 32 | Processed byte count |
| remain_q | output | 32 | Remaining byte count |

## Verification
The main function is tried with a plain continuation of two full blocks, a constant-seeded closed job with a short tail, a closed job that ends exactly on a block boundary, and a full HMAC job with key, data, padding and outer steps. Together they separate the full-slice, padded-tail and padding-only endings, and they show that each one-shot bit clears at its own step. Stalling ready on some jobs shows that the request holds still under back-pressure. A context switch is placed once where bytes remain and once where only the outer step is left, which separates a clean suspend-and-resume from a normal completion.

// File: rtl/hjs_pkg.sv
package hjs_pkg;

  // mode word bit positions (decoded by software and the core)
  localparam int MB_ALGO_LO = 1;
  localparam int MB_CONST   = 3;
  localparam int MB_CLOSE   = 4;
  localparam int MB_KEY     = 5;
  localparam int MB_OUTER   = 7;
  localparam logic [7:0] MODE_KEEP = 8'hBE;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_LEN   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    BK_DATA  = 2'd0,
    BK_KEY   = 2'd1,
    BK_OUTER = 2'd2,
    BK_RSVD  = 2'd3
  } blk_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUSP,
    ST_PICK,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

  typedef enum logic [2:0] {
    STEP_KEY,
    STEP_DATA,
    STEP_PAD,
    STEP_OUTER,
    STEP_PARK,
    STEP_END
  } step_e;

endpackage

// File: rtl/hjs_mode_reg.sv
module hjs_mode_reg
  import hjs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_const,
  input  logic       clr_close,
  input  logic       clr_key,
  input  logic       clr_outer,
  output logic [7:0] mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data & MODE_KEEP;
    end else begin
      if (clr_const) mode_q[MB_CONST] <= 1'b0;
      if (clr_close) mode_q[MB_CLOSE] <= 1'b0;
      if (clr_key)   mode_q[MB_KEY]   <= 1'b0;
      if (clr_outer) mode_q[MB_OUTER] <= 1'b0;
    end
  end

endmodule

// File: rtl/hjs_byte_track.sv
module hjs_byte_track #(
  parameter int LEN_W     = 32,
  parameter int CNT_W     = 32,
  parameter int BLK_BYTES = 64,
  localparam int BB_W     = $clog2(BLK_BYTES + 1),
  localparam int BLK_LG   = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic             job_start,
  input  logic [31:0]      wr_data,
  input  logic             seed_key,
  input  logic             seed_const,
  input  logic             advance,
  input  logic [BB_W-1:0]  adv_bytes,
  output logic [LEN_W-1:0] remain_q,
  output logic [CNT_W-1:0] count_q,
  output logic             rem_nz,
  output logic             rem_short,
  output logic [BB_W-1:0]  chunk
);

  localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(BLK_BYTES);
  localparam logic [CNT_W-1:0] BLK_CNT = CNT_W'(BLK_BYTES);

  logic [CNT_W-1:0] cnt_aligned;

  always_comb begin
    rem_nz      = |remain_q;
    rem_short   = remain_q < BLK_LEN;
    chunk       = rem_short ? remain_q[BB_W-1:0] : BB_W'(BLK_BYTES);
    cnt_aligned = {wr_data[CNT_W-1:BLK_LG], BLK_LG'(0)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      count_q  <= '0;
    end else if (job_start) begin
      remain_q <= wr_data[LEN_W-1:0];
      if (seed_key)
        count_q <= BLK_CNT;
      else if (seed_const)
        count_q <= '0;
    end else if (cnt_wr) begin
      count_q <= cnt_aligned;
    end else if (advance) begin
      remain_q <= remain_q - LEN_W'(adv_bytes);
      count_q  <= count_q + CNT_W'(adv_bytes);
    end
  end

endmodule

// File: rtl/hjs_step_pick.sv
module hjs_step_pick
  import hjs_pkg::*;
(
  input  logic  key_pend,
  input  logic  close_pend,
  input  logic  outer_pend,
  input  logic  rem_nz,
  input  logic  park_pend,
  output step_e step
);

  // order of steps: key block, message data, padding, outer hash
  always_comb begin
    if (key_pend)
      step = STEP_KEY;
    else if (rem_nz)
      step = park_pend ? STEP_PARK : STEP_DATA;
    else if (close_pend)
      step = STEP_PAD;
    else if (outer_pend)
      step = STEP_OUTER;
    else
      step = STEP_END;
  end

endmodule

// File: rtl/hash_job_seq.sv
module hash_job_seq
  import hjs_pkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int CNT_W     = 32,
  parameter int BLK_BYTES = 64,
  localparam int BB_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             ctx_sw_req,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic [1:0]       blk_kind,
  output logic [BB_W-1:0]  blk_bytes,
  output logic             blk_pad,
  output logic             blk_seed_const,
  output logic [1:0]       blk_algo,
  input  logic             blk_done,
  output logic             busy,
  output logic             job_done,
  output logic             suspended,
  output logic [7:0]       mode_q,
  output logic [CNT_W-1:0] count_q,
  output logic [LEN_W-1:0] remain_q
);

  seq_state_e      st;
  step_e           step;
  blk_kind_e       kind_q;
  logic [BB_W-1:0] bytes_q;
  logic            pad_q;
  logic            seed_q;
  logic            park_pend;
  logic            rem_nz;
  logic            rem_short;
  logic [BB_W-1:0] chunk;
  logic            job_start;
  logic            mode_wr;
  logic            cnt_wr;
  logic            blk_fin;
  logic            adv;

  assign busy      = (st == ST_PICK) || (st == ST_REQ) || (st == ST_WAIT);
  assign suspended = (st == ST_SUSP);
  assign job_start = cfg_we && (cfg_sel == SEL_LEN)   && !busy;
  assign mode_wr   = cfg_we && (cfg_sel == SEL_MODE)  && !busy;
  assign cnt_wr    = cfg_we && (cfg_sel == SEL_COUNT) && !busy;
  assign blk_fin   = (st == ST_WAIT) && blk_done;
  assign adv       = blk_fin && (kind_q == BK_DATA);

  hjs_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mode_wr),
    .wr_data   (cfg_wdata[7:0]),
    .clr_const (adv),
    .clr_close (adv && pad_q),
    .clr_key   (blk_fin && (kind_q == BK_KEY)),
    .clr_outer (blk_fin && (kind_q == BK_OUTER)),
    .mode_q    (mode_q)
  );

  hjs_byte_track #(
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .BLK_BYTES (BLK_BYTES)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .job_start  (job_start),
    .wr_data    (cfg_wdata),
    .seed_key   (mode_q[MB_KEY]),
    .seed_const (mode_q[MB_CONST]),
    .advance    (adv),
    .adv_bytes  (bytes_q),
    .remain_q   (remain_q),
    .count_q    (count_q),
    .rem_nz     (rem_nz),
    .rem_short  (rem_short),
    .chunk      (chunk)
  );

  hjs_step_pick u_pick (
    .key_pend   (mode_q[MB_KEY]),
    .close_pend (mode_q[MB_CLOSE]),
    .outer_pend (mode_q[MB_OUTER]),
    .rem_nz     (rem_nz),
    .park_pend  (park_pend),
    .step       (step)
  );

  // sequencing state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind_q   <= BK_DATA;
      bytes_q  <= '0;
      pad_q    <= 1'b0;
      seed_q   <= 1'b0;
      job_done <= 1'b0;
    end else begin
      job_done <= 1'b0;
      unique case (st)
        ST_IDLE, ST_SUSP: begin
          if (job_start) st <= ST_PICK;
        end
        ST_PICK: begin
          unique case (step)
            STEP_KEY: begin
              kind_q  <= BK_KEY;
              bytes_q <= BB_W'(BLK_BYTES);
              pad_q   <= 1'b0;
              seed_q  <= 1'b0;
              st      <= ST_REQ;
            end
            STEP_DATA: begin
              kind_q  <= BK_DATA;
              bytes_q <= chunk;
              pad_q   <= mode_q[MB_CLOSE] && rem_short;
              seed_q  <= mode_q[MB_CONST];
              st      <= ST_REQ;
            end
            STEP_PAD: begin
              kind_q  <= BK_DATA;
              bytes_q <= '0;
              pad_q   <= 1'b1;
              seed_q  <= mode_q[MB_CONST];
              st      <= ST_REQ;
            end
            STEP_OUTER: begin
              kind_q  <= BK_OUTER;
              bytes_q <= '0;
              pad_q   <= 1'b0;
              seed_q  <= 1'b0;
              st      <= ST_REQ;
            end
            STEP_PARK: st <= ST_SUSP;
            default: begin
              st       <= ST_IDLE;
              job_done <= 1'b1;
            end
          endcase
        end
        ST_REQ: begin
          if (blk_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (blk_done) st <= ST_PICK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // context-switch request is held until the job parks or ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      park_pend <= 1'b0;
    else if ((st == ST_PICK) && ((step == STEP_PARK) || (step == STEP_END)))
      park_pend <= 1'b0;
    else if (ctx_sw_req && busy)
      park_pend <= 1'b1;
  end

  assign blk_valid      = (st == ST_REQ);
  assign blk_kind       = kind_q;
  assign blk_bytes      = bytes_q;
  assign blk_pad        = pad_q;
  assign blk_seed_const = seed_q;
  assign blk_algo       = mode_q[MB_ALGO_LO +: 2];

endmodule

// File: rtl/hjs_checker.sv
module hjs_checker #(
  parameter int LEN_W = 32,
  parameter int BB_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic             busy,
  input logic [7:0]       mode_q,
  input logic [LEN_W-1:0] remain_q,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic [1:0]       blk_kind,
  input logic [BB_W-1:0]  blk_bytes,
  input logic             blk_pad,
  input logic             blk_done,
  input logic             job_done,
  input logic             suspended
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_kind) &&
                                 $stable(blk_bytes) && $stable(blk_pad));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !blk_valid);

  p_start_by_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we && (cfg_sel == 2'd2)));

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !blk_done |=> $stable(mode_q));

  p_remain_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> remain_q <= $past(remain_q));

  p_park_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !busy && !job_done);

endmodule

bind hash_job_seq hjs_checker #(.LEN_W(LEN_W), .BB_W(BB_W)) u_hjs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .busy      (busy),
  .mode_q    (mode_q),
  .remain_q  (remain_q),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_kind  (blk_kind),
  .blk_bytes (blk_bytes),
  .blk_pad   (blk_pad),
  .blk_done  (blk_done),
  .job_done  (job_done),
  .suspended (suspended)
);

// File: tb/hash_job_seq_tb_top.sv
module hash_job_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic        ctx_sw_req = 1'b0;
  logic        blk_valid;
  logic        blk_ready = 1'b1;
  logic [1:0]  blk_kind;
  logic [6:0]  blk_bytes;
  logic        blk_pad;
  logic        blk_seed_const;
  logic [1:0]  blk_algo;
  logic        blk_done = 1'b0;
  logic        busy, job_done, suspended;
  logic [7:0]  mode_q;
  logic [31:0] count_q, remain_q;

  int total = 0;
  int fails = 0;

  // core model log
  logic [1:0] lg_kind  [0:15];
  logic [6:0] lg_bytes [0:15];
  logic       lg_pad   [0:15];
  logic       lg_seed  [0:15];
  logic [1:0] lg_algo  [0:15];
  int  nreq = 0;
  bit  done_seen = 0;
  bit  stall = 0;
  int  lat = 1;

  always #5 clk = ~clk;

  hash_job_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctx_sw_req(ctx_sw_req),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_kind(blk_kind),
    .blk_bytes(blk_bytes), .blk_pad(blk_pad), .blk_seed_const(blk_seed_const),
    .blk_algo(blk_algo), .blk_done(blk_done), .busy(busy),
    .job_done(job_done), .suspended(suspended), .mode_q(mode_q),
    .count_q(count_q), .remain_q(remain_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // compression core model: accept, wait, pulse done
  initial begin : core_model
    bit         hold = 0;
    logic [1:0] h_kind;
    logic [6:0] h_bytes;
    logic       h_pad;
    int         tick = 0;
    forever begin
      @(negedge clk);
      if (job_done) done_seen = 1;
      if (hold) begin
        chk(blk_valid && blk_kind == h_kind && blk_bytes == h_bytes &&
            blk_pad == h_pad, "R10 request held under stall",
            {blk_valid, blk_pad, blk_kind, blk_bytes}, {1'b1, h_pad, h_kind, h_bytes});
        hold = 0;
      end
      blk_ready = stall ? (tick % 3 == 2) : 1'b1;
      tick++;
      if (blk_valid && !blk_ready) begin
        hold = 1; h_kind = blk_kind; h_bytes = blk_bytes; h_pad = blk_pad;
      end else if (blk_valid && blk_ready) begin
        if (nreq < 16) begin
          lg_kind[nreq] = blk_kind; lg_bytes[nreq] = blk_bytes;
          lg_pad[nreq] = blk_pad; lg_seed[nreq] = blk_seed_const;
          lg_algo[nreq] = blk_algo;
        end
        nreq++;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (blk_valid) chk(0, "R10 no request while block in flight", 1, 0);
        end
        @(negedge clk);
        if (blk_valid) chk(0, "R10 no request while block in flight", 1, 0);
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic begin_job(input logic [31:0] len);
    nreq = 0; done_seen = 0;
    cfg_write(2'd2, len);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic ctx_pulse();
    ctx_sw_req = 1'b1;
    @(negedge clk);
    ctx_sw_req = 1'b0;
  endtask

  task automatic chk_blk(input int i, input logic [1:0] k, input logic [6:0] b,
                         input logic p, input logic s, input logic [1:0] a,
                         input string tag);
    chk(lg_kind[i] == k && lg_bytes[i] == b && lg_pad[i] == p &&
        lg_seed[i] == s && lg_algo[i] == a, tag,
        {lg_algo[i], lg_seed[i], lg_pad[i], lg_kind[i], lg_bytes[i]},
        {a, s, p, k, b});
  endtask

  task automatic t_reset();
    chk(!busy && !blk_valid && !suspended, "R2 reset idle",
        {busy, blk_valid, suspended}, 0);
    chk(mode_q == 0 && count_q == 0 && remain_q == 0, "R1 reset registers",
        mode_q ^ count_q ^ remain_q, 0);
  endtask

  task automatic t_fields();
    cfg_write(2'd0, 32'hFF);
    chk(mode_q == 8'hBE, "R1 reserved mode bits read 0", mode_q, 8'hBE);
    cfg_write(2'd1, 32'h1234567F);
    chk(count_q == 32'h12345640, "R4 count low bits dropped", count_q, 32'h12345640);
  endtask

  task automatic t_continue();
    cfg_write(2'd0, 32'h06);
    cfg_write(2'd1, 32'h80);
    begin_job(128);
    chk(busy, "R2 busy after length write", busy, 1);
    wait_idle();
    chk(nreq == 2, "R7 two full blocks", nreq, 2);
    chk_blk(0, 2'd0, 7'd64, 0, 0, 2'd3, "R7 first full block");
    chk_blk(1, 2'd0, 7'd64, 0, 0, 2'd3, "R7 second full block");
    chk(count_q == 32'h100 && remain_q == 0, "R7 count and remaining",
        count_q, 32'h100);
    chk(done_seen && mode_q == 8'h06, "R2 done pulse, mode kept", {done_seen, mode_q}, 9'h106);
  endtask

  task automatic t_const_tail();
    stall = 1;
    cfg_write(2'd0, 32'h1A);
    cfg_write(2'd1, 32'h100);
    begin_job(100);
    wait_idle();
    stall = 0;
    chk(nreq == 2, "R8 short tail count of blocks", nreq, 2);
    chk_blk(0, 2'd0, 7'd64, 0, 1, 2'd1, "R5 first block seeded from constants");
    chk_blk(1, 2'd0, 7'd36, 1, 0, 2'd1, "R8 padded short tail");
    chk(count_q == 100, "R5 count forced to 0 then advanced", count_q, 100);
    chk(mode_q == 8'h02, "R5 R8 seed and close cleared", mode_q, 8'h02);
  endtask

  task automatic t_exact_close();
    cfg_write(2'd0, 32'h10);
    cfg_write(2'd1, 32'h40);
    begin_job(64);
    wait_idle();
    chk(nreq == 2, "R8 exact multiple gives pad-only block", nreq, 2);
    chk_blk(0, 2'd0, 7'd64, 0, 0, 2'd0, "R8 full block unpadded");
    chk_blk(1, 2'd0, 7'd0, 1, 0, 2'd0, "R8 pad-only block");
    chk(count_q == 32'h80 && mode_q == 0, "R8 count and close cleared",
        {count_q[23:0], mode_q}, 32'h8000);
  endtask

  task automatic t_hmac();
    lat = 2; stall = 1;
    cfg_write(2'd0, 32'hB4);
    begin_job(64);
    cfg_write(2'd0, 32'h00);
    cfg_write(2'd1, 32'h12340000);
    cfg_write(2'd2, 32'h999);
    wait_idle();
    lat = 1; stall = 0;
    chk(nreq == 4, "R6 R9 four steps", nreq, 4);
    chk_blk(0, 2'd1, 7'd64, 0, 0, 2'd2, "R6 key block first");
    chk_blk(1, 2'd0, 7'd64, 0, 0, 2'd2, "R6 data follows key");
    chk_blk(2, 2'd0, 7'd0, 1, 0, 2'd2, "R8 pad block before outer");
    chk_blk(3, 2'd2, 7'd0, 0, 0, 2'd2, "R9 outer block last");
    chk(count_q == 128 && remain_q == 0, "R3 R6 count 64 plus data, busy writes ignored",
        count_q, 128);
    chk(mode_q == 8'h04, "R3 R6 R9 one-shot bits cleared, busy mode write ignored",
        mode_q, 8'h04);
  endtask

  task automatic t_outer_only();
    cfg_write(2'd0, 32'h86);
    cfg_write(2'd1, 32'h40);
    begin_job(0);
    ctx_pulse();
    wait_idle();
    chk(nreq == 1, "R9 outer-only single step", nreq, 1);
    chk_blk(0, 2'd2, 7'd0, 0, 0, 2'd3, "R9 outer-only request");
    chk(done_seen && !suspended, "R11 switch with no bytes left completes",
        {done_seen, suspended}, 2'b10);
    chk(mode_q == 8'h06 && count_q == 32'h40, "R9 outer cleared, count kept",
        mode_q, 8'h06);
  endtask

  task automatic t_switch();
    cfg_write(2'd0, 32'h1E);
    begin_job(256);
    ctx_pulse();
    wait_idle();
    chk(suspended && !busy && !done_seen, "R11 parked after one block",
        {suspended, busy, done_seen}, 3'b100);
    chk(nreq == 1, "R11 no new request after switch", nreq, 1);
    chk(remain_q == 192 && count_q == 64, "R11 saved length and count",
        remain_q, 192);
    chk(mode_q == 8'h16, "R11 saved mode", mode_q, 8'h16);
    begin_job(192);
    wait_idle();
    chk(!suspended && done_seen && nreq == 4, "R11 resume finishes",
        {suspended, done_seen, nreq[5:0]}, 8'h44);
    chk_blk(0, 2'd0, 7'd64, 0, 0, 2'd3, "R11 resumed block unseeded");
    chk_blk(3, 2'd0, 7'd0, 1, 0, 2'd3, "R11 resumed pad-only");
    chk(count_q == 256 && mode_q == 8'h06, "R11 final count and mode",
        count_q, 256);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_continue();
    t_const_tail();
    t_exact_close();
    t_hmac();
    t_outer_only();
    t_switch();
    summary();
    $finish;
  end

endmodule